// File: doc/BRIEF.md
# Masked Vector Execution Sequencer

This block runs one element-wise addition over two source vectors and writes the sums into a destination vector, under control of a per-element enable mask. Each cycle it drives a read index to the source register file, adds the two returned elements in the same cycle and presents the sum with its index on the destination write port. Where an element's mask bit is clear, nothing is written and the destination keeps its old value.

A parameter picks one of two schedules. The full-sweep schedule visits every element below the vector length, one per cycle, and gates only the write enable with the mask. The skip schedule works through the set mask bits alone, using a lowest-first priority search over the bits still pending, so run time follows the number of set bits and not the vector length. The mask is held inside the block. A reset-all command turns every element on, and a per-element compare writes one bit from the sign of a data word. Each operation works on a copy of the mask taken when it starts.

Top module: `masked_vec_seq`

## Requirements
- R1: After reset, wr_en_o and done_o are low and every mask bit is 1.
- R2: When wr_en_o is high, wr_idx_o equals rd_idx_o and wr_data_o equals src_a_i + src_b_i modulo 2^DATA_W.
- R3: An element whose mask bit is 0 at start is never written, so its destination keeps its old value.
- R4: Only elements with index below the effective length are handled; a vlen_i above NUM_ELEM acts as NUM_ELEM, and a length of 0 writes nothing.
- R5: With DENSITY_TIME=0, in cycle c after the start edge (c counted from 0) element c is presented for every c below the effective length, with wr_en_o equal to its mask bit, and done_o is high in cycle equal to the effective length.
- R6: With DENSITY_TIME=1, the active elements (set mask bit, index below the effective length) are written in ascending index order, one per cycle starting in cycle 0, with wr_en_o high in each such cycle, and done_o is high in the cycle equal to their count.
- R7: done_o is a single-cycle pulse; an operation with no active elements raises it in cycle 0.
- R8: mask_clear_i sets every mask bit to 1 on the next edge and takes priority over a compare in the same cycle.
- R9: cmp_we_i writes mask bit cmp_idx_i with 1 if cmp_data_i, read as a signed two's-complement value, is greater than 0, and with 0 otherwise; other bits are unchanged.
- R10: start_i is ignored while an operation is in progress, and mask commands issued during an operation do not change that operation; they apply to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| vlen_i | input | $clog2(NUM_ELEM+1) | Vector length, sampled at start |
| mask_clear_i | input | 1 | Set every mask bit to 1 |
| cmp_we_i | input | 1 | Write one mask bit from a compare |
| cmp_idx_i | input | $clog2(NUM_ELEM) | Mask bit written by the compare |
| cmp_data_i | input | DATA_W | Element value tested for greater than zero |
| rd_idx_o | output | $clog2(NUM_ELEM) | Source element index |
| src_a_i | input | DATA_W | First source element at rd_idx_o |
| src_b_i | input | DATA_W | Second source element at rd_idx_o |
| wr_en_o | output | 1 | Destination write enable |
| wr_idx_o | output | $clog2(NUM_ELEM) | Destination element index |
| wr_data_o | output | DATA_W | Destination element value |
| done_o | output | 1 | One-cycle end-of-operation pulse |

## Verification
A wrong pending-mask or counter value shows up on the write port in the very cycle it is used, as a write to a wrong index, a missing write or an extra write, so the bench compares every cycle of every operation against a schedule computed from the mask copy and the length. A wrong end condition shows as done_o a cycle early or late, or as activity after done_o. Mask register faults only surface at the next operation's writes, so each mask command is followed by a run that touches every element it could have changed.

// File: rtl/mvs_pkg.sv
package mvs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/mvs_mask_reg.sv
module mvs_mask_reg #(
  parameter int NUM_ELEM = 16,
  parameter int DATA_W   = 16,
  parameter int IDX_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                cmp_we_i,
  input  logic [IDX_W-1:0]    cmp_idx_i,
  input  logic [DATA_W-1:0]   cmp_data_i,
  output logic [NUM_ELEM-1:0] mask_o
);
  logic [NUM_ELEM-1:0] mask_q;
  logic                cmp_gt0;

  assign cmp_gt0 = $signed(cmp_data_i) > $signed({DATA_W{1'b0}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
    end else if (clear_i) begin
      mask_q <= '1;
    end else if (cmp_we_i && (int'(cmp_idx_i) < NUM_ELEM)) begin
      mask_q[cmp_idx_i] <= cmp_gt0;
    end
  end

  assign mask_o = mask_q;

  assert_clear_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (&mask_q));
endmodule

// File: rtl/mvs_prio_enc.sv
module mvs_prio_enc #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  oh_o
);
  // lowest set bit wins: scan downward so the last hit is the smallest index
  always_comb begin
    idx_o = '0;
    oh_o  = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o    = IW'(i);
        oh_o     = '0;
        oh_o[i]  = 1'b1;
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/mvs_lane_alu.sv
module mvs_lane_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o
);
  assign sum_o = a_i + b_i;
endmodule

// File: rtl/mvs_seq.sv
module mvs_seq
  import mvs_pkg::*;
#(
  parameter int NUM_ELEM     = 16,
  parameter int IDX_W        = 4,
  parameter int CNT_W        = 5,
  parameter bit DENSITY_TIME = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [CNT_W-1:0]    vlen_i,
  input  logic [NUM_ELEM-1:0] mask_i,
  output logic                wr_en_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic                done_o
);
  seq_state_e          state_q;
  logic [CNT_W-1:0]    vlen_eff;
  logic [NUM_ELEM-1:0] win;
  logic [NUM_ELEM-1:0] act;
  logic                go;
  logic                empty_w;
  logic                last_w;
  logic                running;

  assign vlen_eff = (vlen_i > CNT_W'(NUM_ELEM)) ? CNT_W'(NUM_ELEM) : vlen_i;

  always_comb begin
    for (int i = 0; i < NUM_ELEM; i++) begin
      win[i] = (i < int'(vlen_eff));
    end
  end

  assign act     = mask_i & win;
  assign go      = (state_q == ST_IDLE) && start_i;
  assign running = (state_q == ST_RUN);
  assign done_o  = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) state_q <= empty_w ? ST_DONE : ST_RUN;
        ST_RUN:  if (last_w)  state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  generate
    if (DENSITY_TIME) begin : g_skip
      logic [NUM_ELEM-1:0] pend_q;
      logic [NUM_ELEM-1:0] pend_oh;
      logic [NUM_ELEM-1:0] pend_nxt;
      logic                pend_any;

      mvs_prio_enc #(.W(NUM_ELEM), .IW(IDX_W)) u_enc (
        .req_i (pend_q),
        .any_o (pend_any),
        .idx_o (idx_o),
        .oh_o  (pend_oh)
      );

      assign pend_nxt = pend_q & ~pend_oh;
      assign empty_w  = (act == '0);
      assign last_w   = (pend_nxt == '0);
      assign wr_en_o  = running && pend_any;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pend_q <= '0;
        end else if (go) begin
          pend_q <= act;
        end else if (running) begin
          pend_q <= pend_nxt;
        end
      end

      assert_skip_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        running |-> wr_en_o);
      assert_skip_drained_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (pend_q == '0));
    end else begin : g_sweep
      logic [NUM_ELEM-1:0] snap_q;
      logic [IDX_W-1:0]    cnt_q;
      logic [CNT_W-1:0]    vlen_q;

      assign empty_w = (vlen_eff == '0);
      assign last_w  = (CNT_W'(cnt_q) + CNT_W'(1)) == vlen_q;
      assign idx_o   = cnt_q;
      assign wr_en_o = running && snap_q[cnt_q];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          snap_q <= '0;
          cnt_q  <= '0;
          vlen_q <= '0;
        end else if (go) begin
          snap_q <= act;
          cnt_q  <= '0;
          vlen_q <= vlen_eff;
        end else if (running && !last_w) begin
          cnt_q <= cnt_q + IDX_W'(1);
        end
      end

      assert_sweep_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        running |-> (CNT_W'(cnt_q) < vlen_q));
      assert_sweep_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running && !last_w) |=> (running && (cnt_q == $past(cnt_q) + IDX_W'(1))));
    end
  endgenerate

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_ascending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o) && $past(running)) |-> (idx_o > $past(idx_o)));
  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !last_w) |=> running);
endmodule

// File: rtl/masked_vec_seq.sv
module masked_vec_seq #(
  parameter int NUM_ELEM     = 16,
  parameter int DATA_W       = 16,
  parameter bit DENSITY_TIME = 1'b0
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              start_i,
  input  logic [$clog2(NUM_ELEM+1)-1:0]     vlen_i,
  input  logic                              mask_clear_i,
  input  logic                              cmp_we_i,
  input  logic [$clog2(NUM_ELEM)-1:0]       cmp_idx_i,
  input  logic [DATA_W-1:0]                 cmp_data_i,
  output logic [$clog2(NUM_ELEM)-1:0]       rd_idx_o,
  input  logic [DATA_W-1:0]                 src_a_i,
  input  logic [DATA_W-1:0]                 src_b_i,
  output logic                              wr_en_o,
  output logic [$clog2(NUM_ELEM)-1:0]       wr_idx_o,
  output logic [DATA_W-1:0]                 wr_data_o,
  output logic                              done_o
);
  localparam int IDX_W = $clog2(NUM_ELEM);
  localparam int CNT_W = $clog2(NUM_ELEM + 1);

  logic [NUM_ELEM-1:0] mask;
  logic [IDX_W-1:0]    idx;

  mvs_mask_reg #(.NUM_ELEM(NUM_ELEM), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (mask_clear_i),
    .cmp_we_i   (cmp_we_i),
    .cmp_idx_i  (cmp_idx_i),
    .cmp_data_i (cmp_data_i),
    .mask_o     (mask)
  );

  mvs_seq #(
    .NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W), .CNT_W(CNT_W), .DENSITY_TIME(DENSITY_TIME)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .vlen_i  (vlen_i),
    .mask_i  (mask),
    .wr_en_o (wr_en_o),
    .idx_o   (idx),
    .done_o  (done_o)
  );

  mvs_lane_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i   (src_a_i),
    .b_i   (src_b_i),
    .sum_o (wr_data_o)
  );

  assign rd_idx_o = idx;
  assign wr_idx_o = idx;

  assert_write_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wr_en_o);
endmodule

// File: tb/tb_masked_vec_seq.sv
module tb_masked_vec_seq;
  localparam int NE = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [4:0]    vlen = '0;
  logic          mclr = 1'b0;
  logic          cmp_we = 1'b0;
  logic [3:0]    cmp_idx = '0;
  logic [DW-1:0] cmp_data = '0;

  logic [3:0]    rd_s, rd_d, wi_s, wi_d;
  logic          we_s, we_d, dn_s, dn_d;
  logic [DW-1:0] wd_s, wd_d;

  logic [DW-1:0] src_a [NE];
  logic [DW-1:0] src_b [NE];
  logic [DW-1:0] dst_s [NE];
  logic [DW-1:0] dst_d [NE];
  logic [NE-1:0] mmask;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  masked_vec_seq #(.NUM_ELEM(NE), .DATA_W(DW), .DENSITY_TIME(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vlen_i(vlen),
    .mask_clear_i(mclr), .cmp_we_i(cmp_we), .cmp_idx_i(cmp_idx), .cmp_data_i(cmp_data),
    .rd_idx_o(rd_s), .src_a_i(src_a[rd_s]), .src_b_i(src_b[rd_s]),
    .wr_en_o(we_s), .wr_idx_o(wi_s), .wr_data_o(wd_s), .done_o(dn_s));

  masked_vec_seq #(.NUM_ELEM(NE), .DATA_W(DW), .DENSITY_TIME(1'b1)) dut_dt (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vlen_i(vlen),
    .mask_clear_i(mclr), .cmp_we_i(cmp_we), .cmp_idx_i(cmp_idx), .cmp_data_i(cmp_data),
    .rd_idx_o(rd_d), .src_a_i(src_a[rd_d]), .src_b_i(src_b[rd_d]),
    .wr_en_o(we_d), .wr_idx_o(wi_d), .wr_data_o(wd_d), .done_o(dn_d));

  always @(posedge clk) begin
    if (we_s) dst_s[wi_s] <= wd_s;
    if (we_d) dst_d[wi_d] <= wd_d;
  end

  function automatic logic gt0(input logic [DW-1:0] v);
    return $signed(v) > 0;
  endfunction

  task automatic check(input string req, input bit ok, input string detail);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", req, detail);
    end
  endtask

  task automatic check_cycle(input string req, input int c,
                             input logic en, input logic [3:0] wi, input logic [3:0] ri,
                             input logic [DW-1:0] wd, input logic dn,
                             input logic e_en, input int e_idx, input logic e_dn);
    bit ok;
    logic [DW-1:0] e_wd;
    e_wd = src_a[e_idx[3:0]] + src_b[e_idx[3:0]];
    ok = (en == e_en) && (dn == e_dn);
    if (e_en) ok = ok && (wi == e_idx[3:0]) && (ri == wi) && (wd == e_wd);
    check(req, ok, $sformatf("cyc %0d act en=%b idx=%0d rd=%0d data=%h done=%b exp en=%b idx=%0d data=%h done=%b",
          c, en, wi, ri, wd, dn, e_en, e_idx, e_wd, e_dn));
  endtask

  task automatic mask_cmd(input bit clr, input bit cw, input int idx, input logic [DW-1:0] d);
    @(negedge clk);
    mclr = clr; cmp_we = cw; cmp_idx = idx[3:0]; cmp_data = d;
    @(negedge clk);
    mclr = 1'b0; cmp_we = 1'b0;
    if (clr) mmask = '1;
    else if (cw) mmask[idx] = gt0(d);
  endtask

  // one operation on both instances, checked cycle by cycle and by destination contents
  task automatic run_op(input string tag, input int vl, input bit disturb);
    int vle, pop, maxc;
    int lst [NE];
    logic [NE-1:0] snap;
    logic [DW-1:0] exp_s [NE];
    logic [DW-1:0] exp_d [NE];
    vle = (vl > NE) ? NE : vl;
    pop = 0;
    for (int i = 0; i < NE; i++) begin
      snap[i] = mmask[i] && (i < vle);
      exp_s[i] = dst_s[i];
      exp_d[i] = dst_d[i];
      if (snap[i]) begin
        lst[pop] = i;
        pop++;
        exp_s[i] = src_a[i] + src_b[i];
        exp_d[i] = src_a[i] + src_b[i];
      end
    end
    maxc = (vle > pop) ? vle : pop;
    @(negedge clk);
    vlen = vl[4:0];
    start = 1'b1;
    for (int c = 0; c <= maxc + 1; c++) begin
      @(negedge clk);
      start = 1'b0;
      mclr = 1'b0; cmp_we = 1'b0;
      if (c == 0 && disturb) begin
        start = 1'b1;
        if (($urandom & 1) != 0) begin
          mclr = 1'b1; mmask = '1;
        end else begin
          cmp_we = 1'b1; cmp_idx = 4'($urandom); cmp_data = DW'($urandom);
          mmask[cmp_idx] = gt0(cmp_data);
        end
      end
      check({tag, "/R5"}, 1'b1, "");
      total--;
      check_cycle({tag, "/R5"}, c, we_s, wi_s, rd_s, wd_s, dn_s,
                  (c < vle) && snap[c < NE ? c : 0], c, c == vle);
      check_cycle({tag, "/R6"}, c, we_d, wi_d, rd_d, wd_d, dn_d,
                  c < pop, (c < pop) ? lst[c] : 0, c == pop);
    end
    mclr = 1'b0; cmp_we = 1'b0; start = 1'b0;
    for (int i = 0; i < NE; i++) begin
      check({tag, "/R3"}, dst_s[i] == exp_s[i],
            $sformatf("sweep dst[%0d] act %h exp %h", i, dst_s[i], exp_s[i]));
      check({tag, "/R3"}, dst_d[i] == exp_d[i],
            $sformatf("skip dst[%0d] act %h exp %h", i, dst_d[i], exp_d[i]));
    end
  endtask

  task automatic fill_src();
    for (int i = 0; i < NE; i++) begin
      src_a[i] = DW'($urandom);
      src_b[i] = DW'($urandom);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog act running exp finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    mmask = '1;
    for (int i = 0; i < NE; i++) begin
      dst_s[i] = '0; dst_d[i] = '0;
    end
    fill_src();
    repeat (3) @(negedge clk);
    // R1: reset outputs
    check("R1", !we_s && !dn_s && !we_d && !dn_d,
          $sformatf("act we=%b%b done=%b%b exp 0000", we_s, we_d, dn_s, dn_d));
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset mask is all ones, full-length run writes everything
    run_op("R1", NE, 1'b0);
    // R2: corner sums that wrap
    src_a[0] = 16'hFFFF; src_b[0] = 16'h0001;
    src_a[1] = 16'h8000; src_b[1] = 16'h8000;
    run_op("R2", 2, 1'b0);
    // R9: compare polarity, zero and extremes
    mask_cmd(1'b0, 1'b1, 0, 16'h0000);
    mask_cmd(1'b0, 1'b1, 3, 16'h8000);
    mask_cmd(1'b0, 1'b1, 5, 16'hFFFF);
    mask_cmd(1'b0, 1'b1, 3, 16'h0001);
    mask_cmd(1'b0, 1'b1, 7, 16'h7FFF);
    mask_cmd(1'b0, 1'b1, 15, 16'h8001);
    fill_src();
    run_op("R9", NE, 1'b0);
    // R4: zero length, then over-range length clamps
    run_op("R4", 0, 1'b0);
    fill_src();
    run_op("R4", 31, 1'b0);
    run_op("R4", 9, 1'b0);
    // R7: all masked off gives done in cycle 0 for skip style
    for (int i = 0; i < NE; i++) mask_cmd(1'b0, 1'b1, i, 16'h0000);
    fill_src();
    run_op("R7", NE, 1'b0);
    // R3: single element at the top end, then at index 0
    mask_cmd(1'b0, 1'b1, 15, 16'h0042);
    run_op("R3", NE, 1'b0);
    mask_cmd(1'b0, 1'b1, 15, 16'h0000);
    mask_cmd(1'b0, 1'b1, 0, 16'h0042);
    run_op("R3", NE, 1'b0);
    // R8: clear wins over a same-cycle compare that would clear bit 4
    mask_cmd(1'b1, 1'b1, 4, 16'hFFF0);
    fill_src();
    run_op("R8", NE, 1'b0);
    // R10: restart and mask commands during a run
    mask_cmd(1'b0, 1'b1, 2, 16'h0000);
    mask_cmd(1'b0, 1'b1, 9, 16'h0000);
    fill_src();
    run_op("R10", 12, 1'b1);
    fill_src();
    run_op("R10", NE, 1'b0);
    // random mix
    for (int n = 0; n < 40; n++) begin
      int k;
      k = int'($urandom_range(6, 0));
      for (int j = 0; j < k; j++)
        mask_cmd(($urandom_range(15, 0) == 0), 1'b1, int'($urandom_range(15, 0)), DW'($urandom));
      fill_src();
      run_op("R5", int'($urandom_range(20, 0)), ($urandom_range(3, 0) == 0));
    end
    finish_run();
  end
endmodule